// File: doc/BRIEF.md
# Atomic Ownership and Load-Linked Reservation Gate

The gate sits in front of a cache request port that several processor IDs share. It gives exclusive ownership of the port to one ID for the length of its read-modify-write sequences. It counts that owner's open RMW pairs and stalls every other ID until the owner is done. A request from the owner that is neither half of an RMW pair ends the ownership at once.

The gate also keeps one load-linked reservation for the port. A locked read sets the reservation to its line when the read completes, and a newer locked read replaces it. A locked (conditional) write looks at the reservation when it is issued. If the reservation matches its line, the write clears it and goes ahead. If not, the write is still accepted, but the response carries a fail flag.

Each request gets a response one cycle later: accept or stall, plus the fail flag. A probe request returns the same accept decision but changes no state. Completions enter on a separate channel.

Top module: `rmw_lock_gate`

## Requirements
- R1: After reset there is no owner, the pair count is zero and there is no reservation. Every request is accepted, and a conditional write fails.
- R2: While an owner exists, a request from any other ID gets a stall response. A stalled request changes no state and never raises the fail flag.
- R3: An accepted RMW-read (kind 3) with no owner makes the requester the owner with a count of one. From the owner, an RMW-read adds one to the count. An RMW-read from the owner while the count is at its maximum (2^CNT_W-1) is stalled.
- R4: An accepted non-probe request from the owner whose kind is neither 3 nor RMW-write (kind 4) ends the ownership and zeroes the count. The request is still accepted.
- R5: An RMW-write completion (kind 4) from the owner takes one from the count. When the count reaches zero the ownership ends.
- R6: An RMW-write completion from an ID that is not the owner, or while there is no owner, raises cmp_err one cycle later and leaves the owner and the count unchanged.
- R7: A locked-read completion (kind 5) sets the reservation to its line and replaces any earlier one.
- R8: An accepted non-probe conditional write (kind 6) to the reserved line clears the reservation, with rsp_sc_fail low. Any other accepted conditional write sets rsp_sc_fail for the one cycle of its response. Either way it is accepted.
- R9: A probe request returns the accept decision that a real request would get. It leaves the owner, the count and the reservation unchanged, and rsp_sc_fail stays low.
- R10: rsp_valid is high exactly one cycle after req_valid. Kinds 0, 1, 2 and 7 are ordinary accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request kind code (see R3, R4, R8, R10) |
| req_pid | input | PID_W | Requesting processor ID |
| req_line | input | LINE_W | Line address of the request |
| req_probe | input | 1 | Evaluate acceptance only, change no state |
| cmp_valid | input | 1 | Completion event present this cycle |
| cmp_kind | input | 3 | Kind of the completing request |
| cmp_pid | input | PID_W | Processor ID of the completing request |
| cmp_line | input | LINE_W | Line address of the completing request |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_accept | output | 1 | Request accepted (low means stall) |
| rsp_sc_fail | output | 1 | Conditional write failed its reservation check |
| cmp_err | output | 1 | RMW-write completion from a non-owner |

## Verification
The sweep covers every ID as owner and every pair count, including the full count. Against each state it issues every request kind from every ID, both as a probe and as a real request. After each request it issues probe requests that reveal the ownership left behind. A gate that let a foreign ID through, did not drop ownership on a plain owner access, or wrapped the count past its maximum would show a wrong accept on those later probes. RMW-write completions from owners and non-owners check the count-down release and the error pulse. Directed cases cover a replaced reservation, a repeated conditional write, and a completion that lands in the same cycle as an owner request. A design that mixed up these orders would fail one conditional write too many or too few, or would lose the owner.

// File: rtl/rlg_pkg.sv
// Package: shared request kind codes for the ownership and reservation gate.
// Assumes: a 3-bit kind field on both the request and completion channels.
package rlg_pkg;
    typedef enum logic [2:0] {
        RQ_LOAD   = 3'd0,
        RQ_STORE  = 3'd1,
        RQ_FETCH  = 3'd2,
        RQ_RMW_RD = 3'd3,
        RQ_RMW_WR = 3'd4,
        RQ_LL_RD  = 3'd5,
        RQ_SC_WR  = 3'd6,
        RQ_SPARE  = 3'd7
    } rq_kind_e;
endpackage

// File: rtl/rlg_owner_track.sv
// Module: tracks which processor ID owns the port for RMW sequences and how
// many RMW pairs it has open; produces the accept decision.
// Assumes: owner register uses its top bit as the "no owner" sentinel, so the
// sentinel can never equal a real ID; completions are applied before the
// same-cycle request.
module rlg_owner_track
    import rlg_pkg::*;
#(
    parameter int PID_W = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_kind,
    input  logic [PID_W-1:0] req_pid,
    input  logic             req_probe,
    input  logic             cmp_valid,
    input  logic [2:0]       cmp_kind,
    input  logic [PID_W-1:0] cmp_pid,
    output logic             grant,
    output logic             cmp_bad,
    output logic [PID_W:0]   owner_q,
    output logic [CNT_W-1:0] depth_q
);
    localparam logic [PID_W:0]   NO_OWNER  = {1'b1, {PID_W{1'b0}}};
    localparam logic [CNT_W-1:0] DEPTH_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] DEPTH_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             owned;
    logic             req_is_owner;
    logic             cmp_is_owner;
    logic             cmp_release;
    logic [PID_W:0]   mid_owner;
    logic [CNT_W-1:0] mid_depth;
    logic [PID_W:0]   nxt_owner;
    logic [CNT_W-1:0] nxt_depth;

    // Decode ownership against the current request and completion.
    always_comb begin
        owned        = !owner_q[PID_W];
        req_is_owner = owned && (owner_q[PID_W-1:0] == req_pid);
        cmp_is_owner = owned && (owner_q[PID_W-1:0] == cmp_pid);
        cmp_release  = cmp_valid && (cmp_kind == RQ_RMW_WR);
        cmp_bad      = cmp_release && !cmp_is_owner;
        grant        = req_valid && (!owned || req_is_owner) &&
                       !((req_kind == RQ_RMW_RD) && req_is_owner && (depth_q == DEPTH_MAX));
    end

    // Apply an RMW-write completion first: count down, release at zero.
    always_comb begin
        mid_owner = owner_q;
        mid_depth = depth_q;
        if (cmp_release && cmp_is_owner) begin
            mid_depth = depth_q - DEPTH_ONE;
            if (depth_q == DEPTH_ONE) begin
                mid_owner = NO_OWNER;
            end
        end
    end

    // Then apply an accepted, non-probe request on top of it.
    always_comb begin
        nxt_owner = mid_owner;
        nxt_depth = mid_depth;
        if (grant && !req_probe) begin
            if (req_kind == RQ_RMW_RD) begin
                nxt_owner = {1'b0, req_pid};
                nxt_depth = mid_depth + DEPTH_ONE;
            end else if (req_is_owner && (req_kind != RQ_RMW_WR)) begin
                nxt_owner = NO_OWNER;
                nxt_depth = '0;
            end
        end
    end

    // Owner and pair-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= NO_OWNER;
            depth_q <= '0;
        end else begin
            owner_q <= nxt_owner;
            depth_q <= nxt_depth;
        end
    end
endmodule

// File: rtl/rlg_resv.sv
// Module: single load-linked reservation (valid bit and line) for the port,
// and the conditional-write pass/fail decision at issue.
// Assumes: the grant input is the same-cycle accept decision; a locked-read
// completion in the same cycle as a matching conditional write wins.
module rlg_resv
    import rlg_pkg::*;
#(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [2:0]        req_kind,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_probe,
    input  logic              cmp_valid,
    input  logic [2:0]        cmp_kind,
    input  logic [LINE_W-1:0] cmp_line,
    output logic              sc_fail,
    output logic              resv_valid_q,
    output logic [LINE_W-1:0] resv_line_q
);
    logic sc_issue;
    logic sc_hit;

    // Decide the conditional write against the held reservation.
    always_comb begin
        sc_issue = grant && !req_probe && (req_kind == RQ_SC_WR);
        sc_hit   = resv_valid_q && (resv_line_q == req_line);
        sc_fail  = sc_issue && !sc_hit;
    end

    // Reservation register: cleared by a passing write, set by a locked read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resv_valid_q <= 1'b0;
            resv_line_q  <= '0;
        end else begin
            if (sc_issue && sc_hit) begin
                resv_valid_q <= 1'b0;
            end
            if (cmp_valid && (cmp_kind == RQ_LL_RD)) begin
                resv_valid_q <= 1'b1;
                resv_line_q  <= cmp_line;
            end
        end
    end
endmodule

// File: rtl/rlg_rsp.sv
// Module: registers the response and error pulses one cycle after the inputs.
// Assumes: all decisions arrive combinationally in the request cycle.
module rlg_rsp (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic grant,
    input  logic sc_fail,
    input  logic cmp_bad,
    output logic rsp_valid,
    output logic rsp_accept,
    output logic rsp_sc_fail,
    output logic cmp_err
);
    // Response stage, all pulses last exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_accept  <= 1'b0;
            rsp_sc_fail <= 1'b0;
            cmp_err     <= 1'b0;
        end else begin
            rsp_valid   <= req_valid;
            rsp_accept  <= grant;
            rsp_sc_fail <= sc_fail;
            cmp_err     <= cmp_bad;
        end
    end
endmodule

// File: rtl/rmw_lock_gate.sv
// Module: top of the atomic ownership and reservation gate. Joins the owner
// tracker, the reservation register and the response stage.
// Assumes: one request and one completion at most per cycle.
module rmw_lock_gate #(
    parameter int PID_W  = 2,
    parameter int CNT_W  = 2,
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [LINE_W-1:0] req_line,
    input  logic              req_probe,
    input  logic              cmp_valid,
    input  logic [2:0]        cmp_kind,
    input  logic [PID_W-1:0]  cmp_pid,
    input  logic [LINE_W-1:0] cmp_line,
    output logic              rsp_valid,
    output logic              rsp_accept,
    output logic              rsp_sc_fail,
    output logic              cmp_err
);
    logic              grant;
    logic              cmp_bad;
    logic              sc_fail;
    logic [PID_W:0]    owner_q;
    logic [CNT_W-1:0]  depth_q;
    logic              resv_valid_q;
    logic [LINE_W-1:0] resv_line_q;

    rlg_owner_track #(.PID_W(PID_W), .CNT_W(CNT_W)) own_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_pid(req_pid),
        .req_probe(req_probe),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_pid(cmp_pid),
        .grant(grant), .cmp_bad(cmp_bad),
        .owner_q(owner_q), .depth_q(depth_q)
    );

    rlg_resv #(.LINE_W(LINE_W)) resv_i (
        .clk(clk), .rst_n(rst_n),
        .grant(grant), .req_kind(req_kind), .req_line(req_line),
        .req_probe(req_probe),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_line(cmp_line),
        .sc_fail(sc_fail),
        .resv_valid_q(resv_valid_q), .resv_line_q(resv_line_q)
    );

    rlg_rsp rsp_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .grant(grant), .sc_fail(sc_fail),
        .cmp_bad(cmp_bad),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .rsp_sc_fail(rsp_sc_fail), .cmp_err(cmp_err)
    );
endmodule

// File: rtl/rmw_lock_gate_chk.sv
// Module: assertion checker for rmw_lock_gate, attached by bind below.
// Assumes: sees the owner, count and reservation registers of the top.
module rmw_lock_gate_chk #(
    parameter int PID_W = 2,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [2:0]       req_kind,
    input logic [PID_W-1:0] req_pid,
    input logic             req_probe,
    input logic             cmp_valid,
    input logic [2:0]       cmp_kind,
    input logic [PID_W-1:0] cmp_pid,
    input logic             rsp_valid,
    input logic             rsp_accept,
    input logic             rsp_sc_fail,
    input logic             cmp_err,
    input logic [PID_W:0]   owner_q,
    input logic [CNT_W-1:0] depth_q,
    input logic             resv_valid_q
);
    a_r1_owner_iff_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        owner_q[PID_W] == (depth_q == '0));

    a_r2_foreign_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !owner_q[PID_W] && (owner_q[PID_W-1:0] != req_pid))
        |=> (rsp_valid && !rsp_accept));

    a_r6_bad_release: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (cmp_kind == 3'd4) &&
         (owner_q[PID_W] || (owner_q[PID_W-1:0] != cmp_pid)))
        |=> cmp_err);

    a_r8_fail_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_sc_fail |-> (rsp_valid && rsp_accept));

    a_r9_probe_still: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe && !cmp_valid)
        |=> ($stable(owner_q) && $stable(depth_q) && $stable(resv_valid_q)));

    a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r10_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_accept && !rsp_sc_fail));

    a_r3_depth_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_probe && !cmp_valid && (req_kind == 3'd3) &&
         (depth_q == {CNT_W{1'b1}}))
        |=> (depth_q == {CNT_W{1'b1}}));
endmodule

bind rmw_lock_gate rmw_lock_gate_chk #(.PID_W(PID_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_kind(req_kind), .req_pid(req_pid),
    .req_probe(req_probe),
    .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_pid(cmp_pid),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .rsp_sc_fail(rsp_sc_fail), .cmp_err(cmp_err),
    .owner_q(owner_q), .depth_q(depth_q), .resv_valid_q(resv_valid_q)
);

// File: tb/rmw_lock_gate_tb_top.sv
`timescale 1ns/1ps
module rmw_lock_gate_tb_top;
    localparam int PID_W  = 2;
    localparam int CNT_W  = 2;
    localparam int LINE_W = 4;
    localparam int NPID   = 1 << PID_W;
    localparam int DMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_kind = '0;
    logic [PID_W-1:0]  req_pid = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic              req_probe = 1'b0;
    logic              cmp_valid = 1'b0;
    logic [2:0]        cmp_kind = '0;
    logic [PID_W-1:0]  cmp_pid = '0;
    logic [LINE_W-1:0] cmp_line = '0;
    logic              rsp_valid, rsp_accept, rsp_sc_fail, cmp_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench reference state
    int m_owner = -1;
    int m_depth = 0;
    bit m_rv = 0;
    int m_rl = 0;

    always #2.5 clk = ~clk;

    rmw_lock_gate #(.PID_W(PID_W), .CNT_W(CNT_W), .LINE_W(LINE_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_pid(req_pid),
        .req_line(req_line), .req_probe(req_probe),
        .cmp_valid(cmp_valid), .cmp_kind(cmp_kind), .cmp_pid(cmp_pid),
        .cmp_line(cmp_line),
        .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
        .rsp_sc_fail(rsp_sc_fail), .cmp_err(cmp_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_owner = -1; m_depth = 0; m_rv = 0; m_rl = 0;
    endtask

    // one request; entered and left at a negedge
    task automatic do_req(input int k, input int pid, input int line, input bit probe);
        bit    exp_acc;
        bit    exp_fail;
        string tag;
        exp_acc  = (m_owner < 0 || m_owner == pid) &&
                   !(k == 3 && m_owner == pid && m_depth == DMAX);
        exp_fail = exp_acc && !probe && k == 6 && !(m_rv && m_rl == line);
        if (probe) tag = "R9";
        else if (m_owner >= 0 && m_owner != pid) tag = "R2";
        else if (k == 3) tag = "R3";
        else if (k == 6) tag = "R8";
        else if (m_owner == pid && k != 4) tag = "R4";
        else tag = "R10";
        req_valid = 1'b1; req_kind = k[2:0]; req_pid = pid[PID_W-1:0];
        req_line = line[LINE_W-1:0]; req_probe = probe;
        @(negedge clk);
        req_valid = 1'b0; req_probe = 1'b0;
        chk("R10", rsp_valid, 1'b1, "rsp_valid");
        chk(tag, rsp_accept, exp_acc, "rsp_accept");
        chk(tag, rsp_sc_fail, exp_fail, "rsp_sc_fail");
        if (exp_acc && !probe) begin
            if (k == 3) begin
                m_owner = pid; m_depth++;
            end else if (m_owner == pid && k != 4) begin
                m_owner = -1; m_depth = 0;
            end
            if (k == 6 && !exp_fail) m_rv = 0;
        end
    endtask

    // one completion; entered and left at a negedge
    task automatic do_cmp(input int k, input int pid, input int line);
        bit exp_err;
        exp_err = (k == 4) && !(m_owner >= 0 && m_owner == pid);
        cmp_valid = 1'b1; cmp_kind = k[2:0]; cmp_pid = pid[PID_W-1:0];
        cmp_line = line[LINE_W-1:0];
        @(negedge clk);
        cmp_valid = 1'b0;
        chk(exp_err ? "R6" : "R5", cmp_err, exp_err, "cmp_err");
        if (k == 4 && !exp_err) begin
            m_depth--;
            if (m_depth == 0) m_owner = -1;
        end
        if (k == 5) begin
            m_rv = 1; m_rl = line;
        end
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state seen at the ports
        chk("R1", rsp_valid, 1'b0, "rsp_valid after reset");
        chk("R1", cmp_err, 1'b0, "cmp_err after reset");
        for (int p = 0; p < NPID; p++) do_req(3, p, 0, 1);
        do_req(6, 2, 5, 0);   // R1: no reservation, so the write fails

        // sweep: owner a with fill pairs, then every kind from every ID
        for (int a = 0; a < NPID; a++)
            for (int fill = 0; fill <= DMAX; fill++)
                for (int b = 0; b < NPID; b++)
                    for (int k = 0; k < 8; k++)
                        for (int pr = 0; pr < 2; pr++) begin
                            do_reset();
                            for (int f = 0; f < fill; f++) do_req(3, a, 0, 0);
                            if (fill[0]) do_cmp(5, 0, b);
                            do_req(k, b, a, pr[0]);
                            do_req(0, (b + 1) % NPID, 0, 1);
                            do_req(3, a, 0, 1);
                            do_req(6, (m_owner < 0) ? 0 : m_owner, a, 0);
                        end

        // R5/R6: completions from owner and non-owners at every count
        for (int a = 0; a < NPID; a++)
            for (int fill = 0; fill <= DMAX; fill++)
                for (int b = 0; b < NPID; b++) begin
                    do_reset();
                    for (int f = 0; f < fill; f++) do_req(3, a, 0, 0);
                    do_cmp(4, b, 0);
                    for (int p = 0; p < NPID; p++) do_req(1, p, 0, 1);
                    do_req(3, a, 0, 1);
                end

        // R7: a newer locked read replaces the reservation
        do_reset();
        do_cmp(5, 0, 3);
        do_cmp(5, 0, 7);
        do_req(6, 1, 3, 0);
        do_cmp(5, 0, 3);
        do_req(6, 1, 3, 0);
        do_req(6, 1, 3, 0);   // R8: second write after clearing fails

        // R5 with R3: completion and owner RMW-read in the same cycle
        do_reset();
        do_req(3, 2, 0, 0);
        req_valid = 1'b1; req_kind = 3'd3; req_pid = 2'd2; req_probe = 1'b0;
        cmp_valid = 1'b1; cmp_kind = 3'd4; cmp_pid = 2'd2;
        @(negedge clk);
        req_valid = 1'b0; cmp_valid = 1'b0;
        chk("R3", rsp_accept, 1'b1, "same-cycle owner rmw read");
        chk("R5", cmp_err, 1'b0, "same-cycle owner completion");
        do_req(0, 1, 0, 1);   // still owned by 2: stall expected
        do_req(0, 2, 0, 0);   // owner plain load ends ownership
        do_req(0, 1, 0, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule